// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block is a full-duplex serial port in which every data bit travels with a serial clock. The transmit path and the receive path work independently. Each path has a one-byte holding register in front of a shift register. Software can therefore queue the next byte while the current one is still on the wire, and can collect a finished byte while the next one is still arriving. Bytes can stream back to back in both directions with no idle clock between them.

The serial clock has two sources, selected by an input. In internal mode the block makes the clock itself. The clock runs at a half period of `HALF_DIV` system cycles, and only while there is transmit work. When the port is idle, the clock is parked high and the data line is held high. In external mode a clock arrives on `sclkIn` and passes through a synchronizer, and its edges drive both shift registers. All logic runs on the system clock. Serial-clock edges reach the shift registers as single-cycle strobes.

Outgoing bits change on the falling edge of the serial clock. Incoming bits are sampled on the rising edge. Bytes are eight bits wide and are sent least significant bit first.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset, `txd` = 1, `sclkOut` = 1, `txEmpty` = 1, `rxFull` = 0 and `rxOverrun` = 0.
- R2: A byte written through `txWrEn`/`txWrData` is sent on `txd` as 8 bits, bit 0 first and bit 7 last.
- R3: `txd` changes only at a falling serial-clock edge. The one exception is internal mode: at the rising edge that samples the last bit, if nothing else is queued, `txd` returns to 1 at that same edge.
- R4: `rxd` is sampled at each rising serial-clock edge. The first sampled bit becomes bit 0. After 8 samples the byte appears on `rxData` and `rxFull` goes to 1.
- R5: `txEmpty` drops to 0 after a write. It returns to 1 at the falling edge that moves the byte into the shift register. A byte queued while another is shifting follows it with no idle clock, so consecutive rising edges stay `2*HALF_DIV` system cycles apart.
- R6: A write while `txEmpty` = 0 is ignored: the queued byte is kept and the written byte is never sent.
- R7: If a byte completes while `rxFull` = 1, `rxOverrun` goes to 1 and `rxData` keeps the earlier byte.
- R8: A one-cycle `rxRdEn` pulse clears `rxFull` and `rxOverrun`.
- R9: In internal mode (`extClkSel` = 0), `sclkOut` toggles every `HALF_DIV` system cycles while data is queued or shifting. Otherwise it stays at 1, and `txd` stays at 1.
- R10: In external mode (`extClkSel` = 1), both paths shift on the edges of `sclkIn` after a `SYNC_STAGES`-flop synchronizer, and `sclkOut` is held at 1.
- R11: Transmit and receive run at the same time. A byte arrives on `rxd` while a different or the same byte leaves on `txd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| extClkSel | input | 1 | 1: serial clock from `sclkIn`; 0: generated internally |
| sclkIn | input | 1 | External serial clock |
| sclkOut | output | 1 | Internally generated serial clock, idle high |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |
| txWrEn | input | 1 | Write strobe for the transmit holding register |
| txWrData | input | 8 | Byte to transmit |
| txEmpty | output | 1 | Transmit holding register can take a byte |
| rxRdEn | input | 1 | Read strobe; acknowledges the received byte |
| rxData | output | 8 | Last accepted received byte |
| rxFull | output | 1 | A received byte is waiting |
| rxOverrun | output | 1 | A byte completed while the previous one was unread |

## Verification
The bench builds the block with `HALF_DIV` = 2, `SYNC_STAGES` = 2 and 8-bit data. With these values a whole byte takes 32 system cycles. That is short enough for a queued second byte, an overrun and an ignored write all to fit in a few hundred cycles. With a half period of two, the gapless check reduces to one exact figure: 60 cycles between the first and the sixteenth rising edge. In internal mode the bench loops `txd` back to `rxd`. It then switches to external mode and drives its own clock, with six-cycle half periods, together with a different receive byte. This leaves room for the two-flop synchronizer delay in both directions.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  // Single-cycle events derived from the serial clock, consumed by the datapath
  typedef struct packed {
    logic fall;     // serial clock falling edge: shift the next transmit bit
    logic rise;     // serial clock rising edge: sample receive bit
    logic retIdle;  // internal mode: line may return high after last bit
  } sclkStrobes_t;
endpackage

// File: rtl/ssx_ctrl.sv
module ssx_ctrl
  import ssx_pkg::*;
#(
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         extSel,
  input  logic         sclkIn,
  input  logic         txPending,
  output logic         sclkOut,
  output sclkStrobes_t str
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  // ---------------- external clock synchronizer ----------------
  logic [SYNC_STAGES:0] syncQ;
  logic extCur, extPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], sclkIn};
  end

  assign extCur  = syncQ[SYNC_STAGES-1];
  assign extPrev = syncQ[SYNC_STAGES];

  // ---------------- internal clock generator ----------------
  logic [CNT_W-1:0] divCnt;
  logic sclkQ, run, tick;

  // keep running while work is queued, and always finish a low phase
  assign run  = txPending || !sclkQ;
  assign tick = run && (divCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ  <= 1'b1;
      divCnt <= '0;
    end else if (extSel || !run) begin
      sclkQ  <= 1'b1;
      divCnt <= '0;
    end else if (tick) begin
      sclkQ  <= ~sclkQ;
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + CNT_W'(1);
    end
  end

  assign sclkOut = sclkQ;

  always_comb begin
    if (extSel) begin
      str.fall    = extPrev & ~extCur;
      str.rise    = ~extPrev & extCur;
      str.retIdle = 1'b0;
    end else begin
      str.fall    = tick & sclkQ;
      str.rise    = tick & ~sclkQ;
      str.retIdle = 1'b1;
    end
  end

  // R9: with nothing queued the generated clock stays parked high
  a_r9_clock_parks: assert property (@(posedge clk) disable iff (!rstN)
    (!extSel && !txPending && sclkQ) |=> sclkQ);

  // R10: external mode never toggles the generated clock
  a_r10_ext_holds_high: assert property (@(posedge clk) disable iff (!rstN)
    extSel |=> sclkOut);
endmodule

// File: rtl/ssx_datapath.sv
module ssx_datapath
  import ssx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sclkStrobes_t      str,
  input  logic              txWrEn,
  input  logic [DATA_W-1:0] txWrData,
  input  logic              rxRdEn,
  input  logic              rxd,
  output logic              txd,
  output logic              txEmpty,
  output logic              txPending,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  output logic              rxOverrun
);
  localparam int BCW = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DATA_W - 1);

  // ---------------- transmit ----------------
  logic [DATA_W-1:0] txHold, txShift;
  logic [BCW-1:0]    txCnt;        // bits still to shift after the one on the line
  logic              holdFull, txdQ, txLoad, wrAcc;

  assign txLoad = str.fall && (txCnt == '0) && holdFull;
  assign wrAcc  = txWrEn && !holdFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold   <= '0;
      txShift  <= '0;
      txCnt    <= '0;
      holdFull <= 1'b0;
      txdQ     <= 1'b1;
    end else begin
      if (str.fall) begin
        if (txCnt != '0) begin
          txdQ    <= txShift[0];
          txShift <= txShift >> 1;
          txCnt   <= txCnt - BCW'(1);
        end else if (holdFull) begin
          txdQ    <= txHold[0];
          txShift <= txHold >> 1;
          txCnt   <= LAST_BIT;
        end else begin
          txdQ    <= 1'b1;
        end
      end else if (str.rise && str.retIdle && (txCnt == '0) && !holdFull) begin
        txdQ <= 1'b1;
      end
      if (wrAcc) txHold <= txWrData;
      holdFull <= wrAcc | (holdFull & ~txLoad);
    end
  end

  assign txd       = txdQ;
  assign txEmpty   = ~holdFull;
  assign txPending = holdFull || (txCnt != '0);

  // R3: the line moves only on a falling edge, or returns high on a rising one
  a_r3_txd_on_edge: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txd) |-> ($past(str.fall) || ($past(str.rise) && txd)));

  // R5: the holding register frees up only when a falling edge reloads
  a_r5_empty_on_reload: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEmpty) |-> $past(str.fall));

  // R6: a write into an occupied holding register leaves it untouched
  a_r6_full_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (txWrEn && holdFull) |=> (txHold == $past(txHold)));

  // ---------------- receive ----------------
  logic [DATA_W-1:0] rxShift, rxHold, rxNext;
  logic [BCW-1:0]    rxCnt;
  logic              rxFullQ, rxOvrQ, rxDone;

  assign rxNext = {rxd, rxShift[DATA_W-1:1]};
  assign rxDone = str.rise && (rxCnt == LAST_BIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxHold  <= '0;
      rxCnt   <= '0;
      rxFullQ <= 1'b0;
      rxOvrQ  <= 1'b0;
    end else begin
      if (str.rise) begin
        rxShift <= rxNext;
        rxCnt   <= rxDone ? '0 : rxCnt + BCW'(1);
      end
      if (rxDone) begin
        if (rxFullQ && !rxRdEn) begin
          rxOvrQ <= 1'b1;
        end else begin
          rxHold  <= rxNext;
          rxFullQ <= 1'b1;
          if (rxRdEn) rxOvrQ <= 1'b0;
        end
      end else if (rxRdEn) begin
        rxFullQ <= 1'b0;
        rxOvrQ  <= 1'b0;
      end
    end
  end

  assign rxData    = rxHold;
  assign rxFull    = rxFullQ;
  assign rxOverrun = rxOvrQ;

  // R4: a byte is delivered only by a rising-edge sample
  a_r4_rx_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> $past(str.rise));

  // R7: an overrun keeps the unread byte in place
  a_r7_overrun_keeps: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxOverrun) |-> (rxFull && $stable(rxData)));

  // R8: a read with no byte completing clears both flags
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rxRdEn && !rxDone) |=> (!rxFull && !rxOverrun));
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import ssx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extClkSel,
  input  logic              sclkIn,
  output logic              sclkOut,
  output logic              txd,
  input  logic              rxd,
  input  logic              txWrEn,
  input  logic [DATA_W-1:0] txWrData,
  output logic              txEmpty,
  input  logic              rxRdEn,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  output logic              rxOverrun
);
  sclkStrobes_t strobes;
  logic         txPending;

  ssx_ctrl #(
    .HALF_DIV   (HALF_DIV),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .extSel   (extClkSel),
    .sclkIn   (sclkIn),
    .txPending(txPending),
    .sclkOut  (sclkOut),
    .str      (strobes)
  );

  ssx_datapath #(
    .DATA_W(DATA_W)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .str      (strobes),
    .txWrEn   (txWrEn),
    .txWrData (txWrData),
    .rxRdEn   (rxRdEn),
    .rxd      (rxd),
    .txd      (txd),
    .txEmpty  (txEmpty),
    .txPending(txPending),
    .rxData   (rxData),
    .rxFull   (rxFull),
    .rxOverrun(rxOverrun)
  );
endmodule

// File: tb/test_sync_serial_xcvr.sv
`timescale 1ns/1ps
module test_sync_serial_xcvr;
  localparam int HALF = 2;
  localparam int EXT_HALF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extClkSel = 1'b0;
  logic sclkIn = 1'b1;
  logic sclkOut, txd, rxd;
  logic txWrEn = 1'b0;
  logic [7:0] txWrData = '0;
  logic txEmpty;
  logic rxRdEn = 1'b0;
  logic [7:0] rxData;
  logic rxFull, rxOverrun;
  logic loopSel = 1'b1;
  logic rxdDrv = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  assign rxd = loopSel ? txd : rxdDrv;

  sync_serial_xcvr #(.DATA_W(8), .HALF_DIV(HALF), .SYNC_STAGES(2)) i_sync_serial_xcvr (
    .clk(clk), .rstN(rstN), .extClkSel(extClkSel), .sclkIn(sclkIn),
    .sclkOut(sclkOut), .txd(txd), .rxd(rxd),
    .txWrEn(txWrEn), .txWrData(txWrData), .txEmpty(txEmpty),
    .rxRdEn(rxRdEn), .rxData(rxData), .rxFull(rxFull), .rxOverrun(rxOverrun)
  );

  // stimulus table: upper byte sent, lower byte expected back over the loop
  localparam logic [15:0] VEC [4] = '{16'hA5A5, 16'h0101, 16'h8080, 16'h3C3C};

  // ---- bench-side observer of the transmit line (internal mode) ----
  logic lastLow = 1'b1;
  logic prevS = 1'b1;
  logic [7:0] capBits = '0;
  int capN = 0;
  int capIdx = 0;
  logic [7:0] capBytes [64];
  int cyc = 0;
  int riseN = 0;
  int riseTimes [64];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!extClkSel) begin
      if (!prevS && sclkOut) begin
        capBits = {lastLow, capBits[7:1]};
        capN = capN + 1;
        if (riseN < 64) riseTimes[riseN] = cyc;
        riseN = riseN + 1;
        if (capN == 8) begin
          capBytes[capIdx % 64] = capBits;
          capIdx = capIdx + 1;
          capN = 0;
        end
      end
      if (!sclkOut) lastLow = txd;
    end
    prevS = sclkOut;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeByte(input logic [7:0] b);
    @(negedge clk);
    txWrEn = 1'b1;
    txWrData = b;
    @(negedge clk);
    txWrEn = 1'b0;
  endtask

  task automatic readByte();
    @(negedge clk);
    rxRdEn = 1'b1;
    @(negedge clk);
    rxRdEn = 1'b0;
  endtask

  task automatic waitRx();
    for (int i = 0; i < 400 && !rxFull; i++) @(negedge clk);
  endtask

  task automatic waitTxEmpty();
    for (int i = 0; i < 400 && !txEmpty; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // ---- R1: reset state ----
    repeat (3) @(negedge clk);
    chk("R1 txd", txd, 1);
    chk("R1 sclkOut", sclkOut, 1);
    chk("R1 txEmpty", txEmpty, 1);
    chk("R1 rxFull", rxFull, 0);
    chk("R1 rxOverrun", rxOverrun, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // ---- table walk: R2 bit order, R4 and R11 loop reception ----
    for (int i = 0; i < 4; i++) begin
      writeByte(VEC[i][15:8]);
      waitRx();
      @(negedge clk);
      chk("R4 R11 rxData", rxData, VEC[i][7:0]);
      chk("R2 txd bit order", capBytes[(capIdx - 1) % 64], VEC[i][15:8]);
      readByte();
    end
    repeat (10) @(negedge clk);
    chk("R9 idle sclkOut", sclkOut, 1);
    chk("R3 R9 idle txd", txd, 1);

    // ---- R5: back-to-back bytes with no gap ----
    riseN = 0;
    writeByte(8'h5A);
    chk("R5 txEmpty low after write", txEmpty, 0);
    waitTxEmpty();
    chk("R5 txEmpty high after reload", txEmpty, 1);
    writeByte(8'hC3);
    chk("R5 second byte queued", txEmpty, 0);
    waitRx();
    chk("R5 first byte", rxData, 8'h5A);
    readByte();
    waitRx();
    chk("R5 second byte", rxData, 8'hC3);
    readByte();
    @(negedge clk);
    chk("R5 rise count", riseN, 16);
    chk("R5 gapless span", riseTimes[15] - riseTimes[0], 15 * 2 * HALF);

    // ---- R6: write while holding register is full ----
    repeat (10) @(negedge clk);
    writeByte(8'h11);
    writeByte(8'h22);
    waitRx();
    chk("R6 kept byte", rxData, 8'h11);
    readByte();
    repeat (60) @(negedge clk);
    chk("R6 dropped byte never sent", rxFull, 0);
    chk("R9 clock parked", sclkOut, 1);

    // ---- R7 overrun, R8 read clears ----
    writeByte(8'h6E);
    waitTxEmpty();
    writeByte(8'h91);
    repeat (80) @(negedge clk);
    chk("R7 rxFull", rxFull, 1);
    chk("R7 rxOverrun", rxOverrun, 1);
    chk("R7 rxData keeps first", rxData, 8'h6E);
    readByte();
    chk("R8 rxFull cleared", rxFull, 0);
    chk("R8 rxOverrun cleared", rxOverrun, 0);

    // ---- R10 external clock, R11 independent directions ----
    begin
      logic [7:0] extCap;
      logic [7:0] rxPat;
      extCap = '0;
      rxPat = 8'hC5;
      @(negedge clk);
      extClkSel = 1'b1;
      loopSel = 1'b0;
      repeat (4) @(negedge clk);
      writeByte(8'h3A);
      for (int b = 0; b < 8; b++) begin
        sclkIn = 1'b0;
        rxdDrv = rxPat[b];
        repeat (EXT_HALF) @(negedge clk);
        extCap[b] = txd;
        sclkIn = 1'b1;
        repeat (EXT_HALF) @(negedge clk);
      end
      chk("R10 R11 ext rxFull", rxFull, 1);
      chk("R10 R11 ext rxData", rxData, rxPat);
      chk("R10 ext txd bits", extCap, 8'h3A);
      chk("R10 sclkOut held", sclkOut, 1);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule